// File: doc/BRIEF.md
# Two-Byte Accumulator Processor Core

A small stored-program processor with a single 8-bit accumulator, an 8-bit program counter and a 256-byte memory that holds both code and data. Every instruction has two bytes: the opcode byte at the program counter and an operand byte right after it. The operand is always a memory address. The core runs a fixed multi-cycle sequence. It fetches the opcode, then fetches the operand, then either touches memory at the operand address or redirects the program counter. A load or add needs one more cycle to return the data byte to the accumulator.

The memory is single-ported and synchronous, and allows one access per cycle. A side port writes program and data images into memory while the core is held in reset. Memory keeps its contents across reset, so a program can be run again without reloading it. The accumulator, the program counter and a halted flag are brought out so the surrounding logic can watch execution.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low, pc_o and acc_o read 0 and halted_o reads 0.
- R2: With rst_ni low, a cycle with ld_en_i high writes ld_data_i to memory at ld_addr_i. Memory is never cleared by reset, so a program loaded once runs again after a later reset.
- R3: Opcode 1 (load) copies mem[operand] into the accumulator. Only opcodes 1 and 2 change the accumulator.
- R4: Opcode 2 (add) adds mem[operand] to the accumulator modulo 256 and keeps no carry.
- R5: Opcode 3 (store) writes the accumulator to mem[operand]. A store into the opcode byte of the instruction that follows it changes what that instruction does.
- R6: After any instruction other than a jump or a halt, the program counter advances by 2 modulo 256. The operand of an instruction at address 255 is read from address 0.
- R7: Opcode 4 (jump) sets the program counter to the operand exactly, including odd addresses.
- R8: Opcode 0 (halt) sets halted_o. After that, pc_o keeps the address of the halt instruction, acc_o is frozen and no memory access is made until reset.
- R9: Opcodes 5 to 255 do nothing except advance the program counter by 2.
- R10: Counting clock edges from the first edge of an instruction, load and add update their results on the 4th edge. Store, jump, halt and unknown opcodes update theirs on the 3rd edge. The next instruction's first edge follows directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the core (not of memory) |
| ld_en_i | input | 1 | Preload write strobe, used only while rst_ni is low |
| ld_addr_i | input | 8 | Preload address |
| ld_data_i | input | 8 | Preload byte |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 8 | Address of the instruction in progress |
| halted_o | output | 1 | Core has executed a halt |

## Verification
Two functions meet in adjacent cycles in two places. In the first, a store's memory write lands on the edge that closes the store, and the opcode fetch of the very next instruction goes out on the following edge. In the second, the program counter wrap and the operand fetch from address 0 happen together. A program that stores a load opcode over the add that follows it provokes the first case: the final accumulator holds 7 if the write was seen in time and 8 if the stale opcode ran. A jump to address 255 provokes the second, whose operand byte is the jump's own opcode at address 0. A behavioural model steps instruction by instruction with the edge counts of R10, and its accumulator, program counter and halted flag are compared with the ports on every clock.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OP_HALT  = 0;
  localparam int unsigned OP_LOAD  = 1;
  localparam int unsigned OP_ADD   = 2;
  localparam int unsigned OP_STORE = 3;
  localparam int unsigned OP_JUMP  = 4;

  typedef enum logic [2:0] {
    ST_OP,
    ST_ARG,
    ST_MEM,
    ST_EXE,
    ST_HALT
  } st_e;

  typedef enum logic [1:0] {
    AS_PC,
    AS_PC1,
    AS_ARG
  } asel_e;

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rdata_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output asel_e         asel_o,
  output logic          pc_inc_o,
  output logic          pc_jmp_o,
  output logic          acc_ld_o,
  output logic          acc_add_o,
  output logic [DW-1:0] op_o,
  output logic          halted_o
);
  st_e           st_q, st_d;
  logic [DW-1:0] op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OP;
      op_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ARG) op_q <= rdata_i;
    end
  end

  always_comb begin
    st_d      = st_q;
    mem_en_o  = 1'b0;
    mem_we_o  = 1'b0;
    asel_o    = AS_PC;
    pc_inc_o  = 1'b0;
    pc_jmp_o  = 1'b0;
    acc_ld_o  = 1'b0;
    acc_add_o = 1'b0;
    unique case (st_q)
      ST_OP: begin
        mem_en_o = 1'b1;
        asel_o   = AS_PC;
        st_d     = ST_ARG;
      end
      ST_ARG: begin
        mem_en_o = 1'b1;
        asel_o   = AS_PC1;
        st_d     = ST_MEM;
      end
      ST_MEM: begin
        // rdata_i holds the operand address this cycle
        if (op_q == DW'(OP_LOAD) || op_q == DW'(OP_ADD)) begin
          mem_en_o = 1'b1;
          asel_o   = AS_ARG;
          st_d     = ST_EXE;
        end else if (op_q == DW'(OP_STORE)) begin
          mem_en_o = 1'b1;
          mem_we_o = 1'b1;
          asel_o   = AS_ARG;
          pc_inc_o = 1'b1;
          st_d     = ST_OP;
        end else if (op_q == DW'(OP_JUMP)) begin
          pc_jmp_o = 1'b1;
          st_d     = ST_OP;
        end else if (op_q == DW'(OP_HALT)) begin
          st_d     = ST_HALT;
        end else begin
          pc_inc_o = 1'b1;
          st_d     = ST_OP;
        end
      end
      ST_EXE: begin
        acc_ld_o  = (op_q == DW'(OP_LOAD));
        acc_add_o = (op_q == DW'(OP_ADD));
        pc_inc_o  = 1'b1;
        st_d      = ST_OP;
      end
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_OP;
    endcase
  end

  assign op_o     = op_q;
  assign halted_o = (st_q == ST_HALT);
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pc_inc_i,
  input  logic          pc_jmp_i,
  input  logic [AW-1:0] jmp_tgt_i,
  input  logic          acc_ld_i,
  input  logic          acc_add_i,
  input  logic [DW-1:0] mem_val_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] pc_next1_o,
  output logic [DW-1:0] acc_o
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(2);

  logic [AW-1:0] pc_q;
  logic [DW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      acc_q <= '0;
    end else begin
      if (pc_jmp_i)      pc_q <= jmp_tgt_i;
      else if (pc_inc_i) pc_q <= pc_q + INSN_BYTES;
      if (acc_ld_i)       acc_q <= mem_val_i;
      else if (acc_add_i) acc_q <= acc_q + mem_val_i;
    end
  end

  assign pc_o       = pc_q;
  assign pc_next1_o = pc_q + AW'(1);
  assign acc_o      = acc_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [DW-1:0] acc_o,
  output logic [AW-1:0] pc_o,
  output logic          halted_o
);
  logic          core_en, core_we;
  asel_e         asel;
  logic          pc_inc, pc_jmp, acc_ld, acc_add;
  logic [DW-1:0] rdata, cur_op;
  logic [AW-1:0] pc, pc_next1, core_addr;
  logic [DW-1:0] acc;

  always_comb begin
    unique case (asel)
      AS_PC1:  core_addr = pc_next1;
      AS_ARG:  core_addr = rdata[AW-1:0];
      default: core_addr = pc;
    endcase
  end

  acc_cpu_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .en_i    (ld_en_i | core_en),
    .we_i    (ld_en_i | core_we),
    .addr_i  (ld_en_i ? ld_addr_i : core_addr),
    .wdata_i (ld_en_i ? ld_data_i : acc),
    .rdata_o (rdata)
  );

  acc_cpu_ctrl #(.DW(DW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rdata_i   (rdata),
    .mem_en_o  (core_en),
    .mem_we_o  (core_we),
    .asel_o    (asel),
    .pc_inc_o  (pc_inc),
    .pc_jmp_o  (pc_jmp),
    .acc_ld_o  (acc_ld),
    .acc_add_o (acc_add),
    .op_o      (cur_op),
    .halted_o  (halted_o)
  );

  acc_cpu_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_inc_i   (pc_inc),
    .pc_jmp_i   (pc_jmp),
    .jmp_tgt_i  (rdata[AW-1:0]),
    .acc_ld_i   (acc_ld),
    .acc_add_i  (acc_add),
    .mem_val_i  (rdata),
    .pc_o       (pc),
    .pc_next1_o (pc_next1),
    .acc_o      (acc)
  );

  assign acc_o = acc;
  assign pc_o  = pc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ld_en_i,
  input logic [DW-1:0] acc_o,
  input logic [AW-1:0] pc_o,
  input logic          halted_o,
  input logic [DW-1:0] cur_op,
  input logic          core_we
);
  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && acc_o == '0 && !halted_o));

  a_r2_preload_in_reset: assert property (@(posedge clk_i)
    ld_en_i |-> !rst_ni);

  a_r3_acc_only_by_load_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o != $past(acc_o)) |->
      ($past(cur_op) == DW'(OP_LOAD) || $past(cur_op) == DW'(OP_ADD)));

  a_r5_store_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_we |=> (pc_o == $past(pc_o) + AW'(2) && !halted_o));

  a_r6_pc_step_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_o != $past(pc_o) && $past(cur_op) != DW'(OP_JUMP)) |->
      pc_o == $past(pc_o) + AW'(2));

  a_r8_halt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o) && $stable(acc_o) && !core_we));
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ld_en_i  (ld_en_i),
  .acc_o    (acc_o),
  .pc_o     (pc_o),
  .halted_o (halted_o),
  .cur_op   (cur_op),
  .core_we  (core_we)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] acc;
  logic [7:0] pc;
  logic       halted;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  // behavioural reference
  logic [7:0] m_mem [256];
  int m_pc = 0, m_acc = 0, m_cnt = 0;
  bit m_halt = 1'b0;
  logic [7:0] img [256];

  always #2 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk_i(clk), .rst_ni(rst_n), .ld_en_i(ld_en), .ld_addr_i(ld_addr),
    .ld_data_i(ld_data), .acc_o(acc), .pc_o(pc), .halted_o(halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_acc = 0; m_halt = 1'b0; m_cnt = 0;
    end else if (!m_halt) begin
      int op, arg;
      op  = int'(m_mem[m_pc]);
      arg = int'(m_mem[(m_pc + 1) & 255]);
      if (m_cnt < 2) m_cnt++;
      else if (m_cnt == 2) begin
        m_cnt = 0;
        case (op)
          0: m_halt = 1'b1;
          1, 2: m_cnt = 3;
          3: begin m_mem[arg] = 8'(m_acc); m_pc = (m_pc + 2) & 255; end
          4: m_pc = arg;
          default: m_pc = (m_pc + 2) & 255;
        endcase
      end else begin
        if (op == 1) m_acc = int'(m_mem[arg]);
        else         m_acc = (m_acc + int'(m_mem[arg])) & 255;
        m_pc  = (m_pc + 2) & 255;
        m_cnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3/R4/R5 acc vs model", int'(acc), m_acc);
      chk("R6/R7/R10 pc vs model", int'(pc), m_pc);
      chk("R8 halted vs model", int'(halted), int'(m_halt));
    end
  end

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  // R2: burn image through the preload port while reset is held
  task automatic burn();
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = img[i];
      m_mem[i] = img[i];
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic run_to_halt();
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
  endtask

  task automatic frozen(input int pc_e, input int acc_e);
    repeat (10) @(negedge clk);
    chk("R8 halted stays", int'(halted), 1);
    chk("R8 pc held at halt", int'(pc), pc_e);
    chk("R8 acc frozen", int'(acc), acc_e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=running expected=halted");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    @(negedge clk); @(negedge clk);
    cmp_on = 1'b1;
    chk("R1 reset pc", int'(pc), 0);
    chk("R1 reset acc", int'(acc), 0);
    chk("R1 reset halted", int'(halted), 0);

    // program A: load, add with wrap, store, reload, add, halt
    clear_img();
    img[0] = 8'd1; img[1] = 8'h80;
    img[2] = 8'd2; img[3] = 8'h81;
    img[4] = 8'd3; img[5] = 8'h82;
    img[6] = 8'd1; img[7] = 8'h83;
    img[8] = 8'd2; img[9] = 8'h82;
    img[10] = 8'd0;
    img[8'h80] = 8'hF0; img[8'h81] = 8'h20; img[8'h83] = 8'h05;
    burn();
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 load not done after 3 edges", int'(pc), 0);
    @(negedge clk);
    chk("R10 load done on 4th edge pc", int'(pc), 2);
    chk("R3 load value", int'(acc), 8'hF0);
    // reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset pc", int'(pc), 0);
    chk("R1 mid-run reset acc", int'(acc), 0);
    run_to_halt();
    chk("R4 add wraps, R5 store feeds reload", int'(acc), 8'h15);
    chk("R8 halt pc", int'(pc), 10);
    frozen(10, 8'h15);

    // program B: odd jump, unknown opcodes
    clear_img();
    img[0] = 8'd4; img[1] = 8'h21;
    img[8'h21] = 8'h07; img[8'h22] = 8'h99;
    img[8'h23] = 8'd1;  img[8'h24] = 8'h50;
    img[8'h25] = 8'hFF; img[8'h26] = 8'h50;
    img[8'h27] = 8'd0;
    img[8'h50] = 8'h3C;
    burn();
    run_to_halt();
    chk("R7 jump odd target, R9 unknown keeps acc", int'(acc), 8'h3C);
    chk("R9 unknown advances pc", int'(pc), 8'h27);
    frozen(8'h27, 8'h3C);

    // program C: opcode at 255, operand from 0, pc wraps
    clear_img();
    img[0] = 8'd4; img[1] = 8'hFF;
    img[2] = 8'h11; img[3] = 8'd0; img[4] = 8'h5A;
    img[8'hFF] = 8'd1;
    burn();
    run_to_halt();
    chk("R6 operand wraps to address 0", int'(acc), 8'h5A);
    chk("R6 pc wraps past 255", int'(pc), 3);

    // program D: store rewrites next opcode
    clear_img();
    img[0] = 8'd1; img[1] = 8'h40;
    img[2] = 8'd3; img[3] = 8'h04;
    img[4] = 8'd2; img[5] = 8'h41;
    img[6] = 8'd0;
    img[8'h40] = 8'd1; img[8'h41] = 8'd7;
    burn();
    run_to_halt();
    chk("R5 rewritten opcode executes", int'(acc), 7);
    chk("R5 halt address", int'(pc), 6);

    // rerun without reload: memory kept across reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears halted", int'(halted), 0);
    run_to_halt();
    chk("R2 memory survives reset", int'(acc), 7);
    chk("R2 rerun halt address", int'(pc), 6);
    frozen(6, 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule